// File: doc/BRIEF.md
# Tap-Counting CW Speedometer

This block estimates Morse sending speed by counting key closures over a fixed measurement window. Ordinary English text averages two and a half key closures per letter. That makes twelve and a half closures per five-letter word. The block therefore counts closures over 60 / 12.5 = 4.8 seconds, and the raw two-digit count reads directly as words per minute.

A slow timebase tick advances a window counter. The active-low key input is synchronized and debounced, and each press yields one count into a two-digit BCD tally (units, then tens). When the window ends, a one-cycle latch pulse copies the tally into the display registers. A one-cycle clear pulse follows and restarts the tally for the next window. The latched digits and their seven-segment patterns stay steady while the next window counts.

Top module: `tap_speedometer`

## Requirements
- R1: After reset, both digit outputs are 0 and both segment outputs show the pattern for 0 (7'h3F).
- R2: `key_n` is active low. Each press, meaning a high-to-low change seen after the synchronizer, adds exactly one to the tally. The tally is kept as BCD, with units in `units_o` and tens in `tens_o` once latched.
- R3: After the debounced key level changes, any further change is ignored for HOLDOFF clock cycles. A press whose contacts bounce within that hold-off counts once.
- R4: A window with more than 99 presses reports 99.
- R5: A window spans WINDOW_TICKS cycles in which `tick` is high. The outputs take the new result on the clock edge after the edge that samples the final tick, and not earlier.
- R6: Between latches, the digit and segment outputs do not change, whatever the key does.
- R7: Every window starts from zero, so a window with no presses reports 00.
- R8: A press whose count is due in the latch cycle or the clear cycle is not lost. It is credited to the following window, and not to the one being latched.
- R9: The segment outputs are active high, with bit 6..0 = g,f,e,d,c,b,a. Digits 0..9 map to 3F,06,5B,4F,66,6D,7D,07,7F,6F.
- R10: The latch pulse lasts one cycle and the clear pulse follows it in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| key_n | input | 1 | Key or trigger input, low while closed |
| units_o | output | 4 | Latched units digit (BCD) |
| tens_o | output | 4 | Latched tens digit (BCD) |
| seg_units_o | output | 7 | Segment pattern for the units digit (g..a) |
| seg_tens_o | output | 7 | Segment pattern for the tens digit (g..a) |

## Verification
Suppose a key falls before clock edge E0. The press reaches the tally at edge E3: two synchronizer stages plus the registered count strobe. The bench therefore holds each press and each release for eight cycles, which covers both that delay and the hold-off. When the final tick is sampled at edge E, the latch strobe rises after E, and the digits and segments change at E+1. The bench samples at the falling edge after E, where the old value must still show, and again one cycle later, where the new value must show. For the boundary presses, the key fall is placed so that the press's count strobe coincides exactly with the latch cycle in one case and with the clear cycle in the other.

// File: rtl/cwspd_pkg.sv
package cwspd_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // Active-high segment pattern, bit order g,f,e,d,c,b,a.
  function automatic seg_t bcd_to_seg(input bcd_t d);
    seg_t s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cwspd_keyin.sv
module cwspd_keyin #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic key_n,
  output logic tap_o
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLDOFF);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   key_s;
  logic                   level_q;
  logic [HW-1:0]          hold_q;

  assign key_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], key_n};
  end

  // Debounced level: accepts a change only once the hold-off has run out.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      hold_q  <= '0;
      tap_o   <= 1'b0;
    end else begin
      tap_o <= 1'b0;
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else if (key_s != level_q) begin
        level_q <= key_s;
        hold_q  <= HOLD_INIT;
        tap_o   <= level_q & ~key_s;
      end
    end
  end

endmodule

// File: rtl/cwspd_window.sv
module cwspd_window #(
  parameter int WINDOW_TICKS = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic latch_o,
  output logic clear_o
);
  localparam int TW = $clog2(WINDOW_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(WINDOW_TICKS - 1);

  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q  <= '0;
      latch_o <= 1'b0;
      clear_o <= 1'b0;
    end else begin
      latch_o <= 1'b0;
      clear_o <= latch_o;
      if (tick) begin
        if (tcnt_q == LAST) begin
          tcnt_q  <= '0;
          latch_o <= 1'b1;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cwspd_tally.sv
module cwspd_tally
  import cwspd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic latch,
  input  logic clear,
  output bcd_t units_o,
  output bcd_t tens_o
);
  logic carry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      units_o <= '0;
      tens_o  <= '0;
      carry_q <= 1'b0;
    end else if (clear) begin
      // New window starts with any press parked during latch or clear.
      units_o <= {3'b000, carry_q} + {3'b000, tap};
      tens_o  <= '0;
      carry_q <= 1'b0;
    end else begin
      if (latch) carry_q <= tap;
      if (tap && !latch) begin
        if (units_o == 4'd9) begin
          if (tens_o != 4'd9) begin
            units_o <= '0;
            tens_o  <= tens_o + 4'd1;
          end
        end else begin
          units_o <= units_o + 4'd1;
        end
      end
    end
  end

endmodule

// File: rtl/cwspd_disp.sv
module cwspd_disp
  import cwspd_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                latch,
  input  logic [4*DIGITS-1:0] cnt_i,
  output logic [4*DIGITS-1:0] digit_o,
  output logic [7*DIGITS-1:0] seg_o
);
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    always_ff @(posedge clk) begin
      if (rst) begin
        digit_o[4*i +: 4] <= '0;
        seg_o[7*i +: 7]   <= bcd_to_seg(4'd0);
      end else if (latch) begin
        digit_o[4*i +: 4] <= cnt_i[4*i +: 4];
        seg_o[7*i +: 7]   <= bcd_to_seg(cnt_i[4*i +: 4]);
      end
    end
  end

endmodule

// File: rtl/tap_speedometer.sv
module tap_speedometer
  import cwspd_pkg::*;
#(
  parameter int WINDOW_TICKS = 480,
  parameter int HOLDOFF      = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       key_n,
  output logic [3:0] units_o,
  output logic [3:0] tens_o,
  output logic [6:0] seg_units_o,
  output logic [6:0] seg_tens_o
);
  logic tap;
  logic latch_p;
  logic clear_p;
  bcd_t cnt_units;
  bcd_t cnt_tens;

  cwspd_keyin #(.SYNC_STAGES(SYNC_STAGES), .HOLDOFF(HOLDOFF)) u_keyin (
    .clk(clk), .rst(rst), .key_n(key_n), .tap_o(tap)
  );

  cwspd_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
    .clk(clk), .rst(rst), .tick(tick), .latch_o(latch_p), .clear_o(clear_p)
  );

  cwspd_tally u_tally (
    .clk(clk), .rst(rst), .tap(tap), .latch(latch_p), .clear(clear_p),
    .units_o(cnt_units), .tens_o(cnt_tens)
  );

  cwspd_disp #(.DIGITS(2)) u_disp (
    .clk(clk), .rst(rst), .latch(latch_p),
    .cnt_i({cnt_tens, cnt_units}),
    .digit_o({tens_o, units_o}),
    .seg_o({seg_tens_o, seg_units_o})
  );

endmodule

// File: rtl/tap_speedometer_chk.sv
module tap_speedometer_chk (
  input logic       clk,
  input logic       rst,
  input logic       tap,
  input logic       latch_p,
  input logic       clear_p,
  input logic [3:0] cnt_units,
  input logic [3:0] cnt_tens,
  input logic [3:0] units_o,
  input logic [3:0] tens_o,
  input logic [6:0] seg_units_o
);
  // R10
  clear_follows_latch_chk: assert property (@(posedge clk) disable iff (rst)
    latch_p |=> (clear_p && !latch_p));

  // R10
  clear_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
    clear_p |-> $past(latch_p));

  // R6
  display_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(latch_p) |-> ($stable(units_o) && $stable(tens_o) && $stable(seg_units_o)));

  // R4
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_units <= 4'd9) && (cnt_tens <= 4'd9));

  // R3
  tap_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tap |=> !tap);

  // R7
  fresh_window_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clear_p) |-> (cnt_tens == 4'd0 && cnt_units <= 4'd2));

endmodule

bind tap_speedometer tap_speedometer_chk u_chk (
  .clk(clk), .rst(rst), .tap(tap), .latch_p(latch_p), .clear_p(clear_p),
  .cnt_units(cnt_units), .cnt_tens(cnt_tens),
  .units_o(units_o), .tens_o(tens_o), .seg_units_o(seg_units_o)
);

// File: tb/tap_speedometer_test.sv
module tap_speedometer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 10;
  localparam int HO = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       key_n = 1'b1;
  logic [3:0] units_o, tens_o;
  logic [6:0] seg_units_o, seg_tens_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tap_speedometer #(.WINDOW_TICKS(W), .HOLDOFF(HO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .tick(tick), .key_n(key_n),
    .units_o(units_o), .tens_o(tens_o),
    .seg_units_o(seg_units_o), .seg_tens_o(seg_tens_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int value);
    int act;
    act = tens_o * 10 + units_o;
    n_chk++;
    if (act != value) begin
      n_bad++;
      $display("FAIL %s: display %0d expected %0d", req, act, value);
    end
    n_chk++;
    if (seg_units_o != exp_seg(value % 10) || seg_tens_o != exp_seg(value / 10)) begin
      n_bad++;
      $display("FAIL R9 (%s): segs %h/%h expected %h/%h", req, seg_tens_o, seg_units_o,
               exp_seg(value / 10), exp_seg(value % 10));
    end
  endtask

  task automatic press();
    @(negedge clk) key_n = 1'b0;
    repeat (8) @(negedge clk);
    key_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic presses(input int n);
    for (int i = 0; i < n; i++) press();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic close_and_check(input string req, input int value);
    ticks(W);
    repeat (2) @(negedge clk);
    check(req, value);
  endtask

  // R1
  task automatic t_reset();
    check("R1 reset", 0);
  endtask

  // R2, R5: seven presses; exact latch edge
  task automatic t_basic_and_timing();
    presses(7);
    ticks(W - 1);
    check("R5 before final tick", 0);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R5 latch cycle keeps old", 0);
    @(negedge clk);
    check("R2 R5 seven presses", 7);
  endtask

  // R6: display holds while next window counts
  task automatic t_hold();
    presses(12);
    check("R6 mid window hold", 7);
    presses(11);
    check("R6 mid window hold", 7);
    close_and_check("R2 twenty-three", 23);
  endtask

  // R7
  task automatic t_empty();
    close_and_check("R7 empty window", 0);
  endtask

  task automatic t_more();
    presses(46);
    close_and_check("R2 forty-six", 46);
    presses(58);
    close_and_check("R2 fifty-eight", 58);
  endtask

  // R4
  task automatic t_saturate();
    presses(105);
    close_and_check("R4 saturation", 99);
  endtask

  // R3: contact bounce inside hold-off
  task automatic t_bounce();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) key_n = 1'b0;
      @(negedge clk) key_n = 1'b1;
      @(negedge clk) key_n = 1'b0;
      @(negedge clk) key_n = 1'b1;
      @(negedge clk) key_n = 1'b0;
      repeat (8) @(negedge clk);
      key_n = 1'b1;
      @(negedge clk) key_n = 1'b0;
      @(negedge clk) key_n = 1'b1;
      @(negedge clk) key_n = 1'b0;
      @(negedge clk) key_n = 1'b1;
      repeat (8) @(negedge clk);
    end
    close_and_check("R3 bounced presses", 3);
  endtask

  // R8: press strobe lands on latch cycle, then on clear cycle
  task automatic t_boundary();
    presses(2);
    ticks(W - 1);
    @(negedge clk) key_n = 1'b0;   // before E0
    @(negedge clk);                // after E0
    @(negedge clk) tick = 1'b1;    // sampled at E2 with the strobe
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    check("R8 latch-cycle press excluded", 2);
    repeat (6) @(negedge clk);
    key_n = 1'b1;
    repeat (8) @(negedge clk);
    ticks(W - 1);
    @(negedge clk) key_n = 1'b0;   // before E0
    @(negedge clk) tick = 1'b1;    // sampled at E1, clear in strobe cycle
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 carried press", 1);
    repeat (6) @(negedge clk);
    key_n = 1'b1;
    repeat (8) @(negedge clk);
    close_and_check("R8 clear-cycle press kept", 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_and_timing();
    t_hold();
    t_empty();
    t_more();
    t_saturate();
    t_bounce();
    t_boundary();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule